// File: doc/BRIEF.md
# Performance-Monitor Interval Countdown Timer

This block sets the sampling window for event counters elsewhere on the chip. Software writes a control word and a reload value through a simple write port. Once it is enabled, the timer counts down from the reload value. It advances once per clock, or once every 2^k clocks when the prescale field holds k. While the window is open it drives an event output, which other counters can use as their count-enable. In one-shot mode the timer stops at the end of the interval and raises a sticky expired flag. In repeat mode it reloads and starts the same interval again.

The timer can also be stopped by hardware. A 3-bit select picks one of seven external sources: the local counter status, two global events, or one of four active-low event pins. The stop is edge-triggered. When the selected source becomes active, the enable bit and the repeat bit are both cleared in the same cycle. A self-clearing soft-reset bit in the control word returns every timer register to its default value.

The control FSM has three states:
- `ST_IDLE`: the timer is stopped.
- `ST_RUN`: the timer is counting.
- `ST_CLR`: a one-cycle soft-reset state.

The transitions are:
- `ST_IDLE` to `ST_RUN` on a control write that sets enable, unless a disable edge arrives in the same cycle.
- `ST_RUN` to `ST_IDLE` when any of these happens:
  - a control write clears enable;
  - the selected disable edge arrives;
  - a one-shot interval expires.
- Any state to `ST_CLR` on a control write with the soft-reset bit set.
- `ST_CLR` to `ST_IDLE` unconditionally, one cycle later.

Top module: `pm_interval_timer`

## Requirements
- R1: After reset, `evt_o` is 0, `expired_o` is 0 and `count_o` is 0.
- R2: A write with `wr_addr`=1 stores `wr_data` as the reload value. If the timer is stopped, the same write also loads `count_o`. A control write (`wr_addr`=0) with bit 0 set starts the timer, loading `count_o` from the reload value. `count_o` then drops by one on each prescaled tick.
- R3: Control bits 3:1 hold k. A tick occurs every 2^k clocks (1 to 128), and the prescale phase restarts each time the timer starts.
- R4: With control bit 7 clear (one-shot), a tick at a count of 1 or 0 ends the interval. `count_o` becomes 0, the timer stops and `expired_o` becomes 1. `expired_o` stays 1 until the next start.
- R5: With control bit 7 set (repeat), a tick at a count of 1 or 0 reloads `count_o` from the reload value, and the timer keeps running.
- R6: Control bits 13:11 select the disable source:
  - 0: none;
  - 1: `local_stat`;
  - 2: `gev[0]`;
  - 3: `gev[1]`;
  - 4 to 7: `ev_n[0]` to `ev_n[3]`.

  Each source is registered once. A rising edge on an active-high source, or a falling edge on an active-low pin, stops a running timer two clocks after the pin changes. The stop clears the enable and repeat bits.
- R7: A disable source held at its active level does not stop a timer started later, and a deactivating edge has no effect. An edge that arrives while the timer is stopped leaves `count_o` unchanged. If a control write setting enable lands in the same cycle as a disable edge, the timer stays stopped.
- R8: When control bit 15 is 0, `evt_o` stays 0 whatever the timer is doing.
- R9: Control bits 5:4 pick the output behaviour when bit 15 is 1:
  - 00: `evt_o` is high while the timer runs;
  - 01: a one-clock pulse after each expiry;
  - 10: `evt_o` toggles at each expiry;
  - 11: `evt_o` stays low.
- R10: A control write with bit 6 set clears all timer state to the reset values and enters a one-cycle clear state. Writes during that cycle are ignored, and the bit reads as clear afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the reload value |
| wr_data | input | 16 | Write data |
| local_stat | input | 1 | Local counter status condition, active high |
| gev | input | 2 | Global events, active high |
| ev_n | input | 4 | Event pins, active low |
| evt_o | output | 1 | Timer status event output |
| expired_o | output | 1 | Sticky one-shot expiry flag |
| count_o | output | CNT_W | Current down-counter value |

## Verification
The bench targets these corner cases:
- **Source polarity and select decoding.** Each of the seven disable sources is fired, and a source other than the selected one is also fired. A swapped polarity or a wrong select decode would leave the timer running, or stop it on the wrong pin.
- **Level versus edge.** A source is held active before the timer starts, and an edge arrives while the timer is stopped. A level-sensitive design would refuse to start, and a careless one would disturb the count.
- **Same-cycle race.** An enabling write coincides with a disable edge. A design that lets the write win would start counting.
- **Prescale and mode extremes.** The largest prescale is run, as is a repeat interval of one tick. An off-by-one in the tick mask or in the reload point shifts every later count.
- **Soft reset.** A write issued in the cycle straight after a soft reset is checked. A design that accepted it would restart the timer.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
    // control word layout
    localparam int CTRL_W  = 16;
    localparam int BIT_EN  = 0;
    localparam int PS_LO   = 1;
    localparam int PS_W    = 3;
    localparam int MD_LO   = 4;
    localparam int BIT_SR  = 6;
    localparam int BIT_REP = 7;
    localparam int SEL_LO  = 11;
    localparam int SEL_W   = 3;
    localparam int BIT_OE  = 15;
    localparam int N_EVPIN = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CLR  = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        MD_LEVEL  = 2'd0,
        MD_PULSE  = 2'd1,
        MD_TOGGLE = 2'd2,
        MD_RSVD   = 2'd3
    } out_mode_e;
endpackage

// File: rtl/pmt_src_edge.sv
`timescale 1ns/1ps
module pmt_src_edge
    import pmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               local_stat,
    input  logic [1:0]         gev,
    input  logic [N_EVPIN-1:0] ev_n,
    input  logic [SEL_W-1:0]   sel,
    output logic               dis_edge
);
    localparam int NSRC = 3 + N_EVPIN;

    // index 0 is the "no source" slot, held inactive
    logic [NSRC:0] act_raw, act_q, act_qq, rise;

    assign act_raw = {~ev_n, gev, local_stat, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            act_qq <= '0;
        end else begin
            act_q  <= act_raw;
            act_qq <= act_q;
        end
    end

    assign rise = act_q & ~act_qq;

    always_comb begin
        dis_edge = 1'b0;
        for (int i = 0; i <= NSRC; i++) begin
            if (sel == SEL_W'(i)) dis_edge = rise[i];
        end
    end
endmodule

// File: rtl/pmt_prescale.sv
`timescale 1ns/1ps
module pmt_prescale
    import pmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pcnt, mask;

    assign mask = ~({PC_W{1'b1}} << ps);
    assign tick = run && (pcnt >= mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pcnt <= '0;
        else if (!run || tick) pcnt <= '0;
        else                   pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pmt_core.sv
`timescale 1ns/1ps
module pmt_core
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tick,
    input  logic              dis_edge,
    output logic              run_o,
    output logic [PS_W-1:0]   ps_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              expired_o,
    output logic              evt_o
);
    tmr_state_e state_q, n_state;
    out_mode_e  md_q, n_md;
    logic en_q, rep_q, oe_q, exp_q;
    logic n_en, n_rep, n_oe, n_exp;
    logic [PS_W-1:0]  ps_q, n_ps;
    logic [SEL_W-1:0] sel_q, n_sel;
    logic [CNT_W-1:0] cnt_q, n_cnt, reload_q, n_reload;
    logic wr_ctl, wr_rl, sr_req, expire;
    logic pulse_q, tog_q;

    always_comb begin
        wr_ctl   = wr_en && !wr_addr && (state_q != ST_CLR);
        wr_rl    = wr_en &&  wr_addr && (state_q != ST_CLR);
        sr_req   = wr_ctl && wr_data[BIT_SR];
        n_state  = state_q;
        n_en     = en_q;
        n_rep    = rep_q;
        n_oe     = oe_q;
        n_md     = md_q;
        n_ps     = ps_q;
        n_sel    = sel_q;
        n_cnt    = cnt_q;
        n_reload = reload_q;
        n_exp    = exp_q;
        expire   = 1'b0;
        if (sr_req) begin
            n_state  = ST_CLR;
            n_en     = 1'b0;
            n_rep    = 1'b0;
            n_oe     = 1'b0;
            n_md     = MD_LEVEL;
            n_ps     = '0;
            n_sel    = '0;
            n_cnt    = '0;
            n_reload = '0;
            n_exp    = 1'b0;
        end else begin
            if (wr_ctl) begin
                n_en  = wr_data[BIT_EN];
                n_rep = wr_data[BIT_REP];
                n_oe  = wr_data[BIT_OE];
                n_md  = out_mode_e'(wr_data[MD_LO +: 2]);
                n_ps  = wr_data[PS_LO +: PS_W];
                n_sel = wr_data[SEL_LO +: SEL_W];
            end
            if (wr_rl) begin
                n_reload = wr_data[CNT_W-1:0];
                if (state_q == ST_IDLE) n_cnt = wr_data[CNT_W-1:0];
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (n_en) begin
                        if (dis_edge) begin
                            n_en  = 1'b0;
                            n_rep = 1'b0;
                        end else begin
                            n_state = ST_RUN;
                            n_cnt   = reload_q;
                            n_exp   = 1'b0;
                        end
                    end
                end
                ST_RUN: begin
                    if (dis_edge) begin
                        n_en    = 1'b0;
                        n_rep   = 1'b0;
                        n_state = ST_IDLE;
                    end else if (!n_en) begin
                        n_state = ST_IDLE;
                    end else if (tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            expire = 1'b1;
                            if (n_rep) begin
                                n_cnt = reload_q;
                            end else begin
                                n_cnt   = '0;
                                n_en    = 1'b0;
                                n_exp   = 1'b1;
                                n_state = ST_IDLE;
                            end
                        end else begin
                            n_cnt = cnt_q - 1'b1;
                        end
                    end
                end
                ST_CLR:  n_state = ST_IDLE;
                default: n_state = ST_IDLE;
            endcase
        end
    end

    // state register and control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            en_q     <= 1'b0;
            rep_q    <= 1'b0;
            oe_q     <= 1'b0;
            md_q     <= MD_LEVEL;
            ps_q     <= '0;
            sel_q    <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            exp_q    <= 1'b0;
        end else begin
            state_q  <= n_state;
            en_q     <= n_en;
            rep_q    <= n_rep;
            oe_q     <= n_oe;
            md_q     <= n_md;
            ps_q     <= n_ps;
            sel_q    <= n_sel;
            cnt_q    <= n_cnt;
            reload_q <= n_reload;
            exp_q    <= n_exp;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else if (sr_req) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= expire;
            tog_q   <= tog_q ^ expire;
        end
    end

    always_comb begin
        unique case (md_q)
            MD_LEVEL:  evt_o = oe_q && (state_q == ST_RUN);
            MD_PULSE:  evt_o = oe_q && pulse_q;
            MD_TOGGLE: evt_o = oe_q && tog_q;
            default:   evt_o = 1'b0;
        endcase
    end

    assign run_o     = (state_q == ST_RUN);
    assign ps_o      = ps_q;
    assign sel_o     = sel_q;
    assign count_o   = cnt_q;
    assign expired_o = exp_q;
endmodule

// File: rtl/pm_interval_timer.sv
`timescale 1ns/1ps
module pm_interval_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic               local_stat,
    input  logic [1:0]         gev,
    input  logic [N_EVPIN-1:0] ev_n,
    output logic               evt_o,
    output logic               expired_o,
    output logic [CNT_W-1:0]   count_o
);
    logic             run_w, tick_w, dis_w;
    logic [PS_W-1:0]  ps_w;
    logic [SEL_W-1:0] sel_w;

    pmt_src_edge u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_stat (local_stat),
        .gev        (gev),
        .ev_n       (ev_n),
        .sel        (sel_w),
        .dis_edge   (dis_w)
    );

    pmt_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .ps    (ps_w),
        .tick  (tick_w)
    );

    pmt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tick      (tick_w),
        .dis_edge  (dis_w),
        .run_o     (run_w),
        .ps_o      (ps_w),
        .sel_o     (sel_w),
        .count_o   (count_o),
        .expired_o (expired_o),
        .evt_o     (evt_o)
    );
endmodule

// File: rtl/pmt_checker.sv
`timescale 1ns/1ps
module pmt_checker
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       state,
    input logic             wr_en,
    input logic             tick,
    input logic             dis_edge,
    input logic             rep,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             expired
);
    // R2: a stopped timer with no write keeps its count
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_en) |=> $stable(count));

    // R4: the sticky flag rises only with the counter at zero and stopped
    a_r4_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> (count == '0 && state == ST_IDLE));

    // R5: repeat expiry reloads and keeps running
    a_r5_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && rep && count <= CNT_W'(1) && !dis_edge && !wr_en)
        |=> (state == ST_RUN && count == reload));

    // R6: the selected edge stops a running timer and drops repeat
    a_r6_disable_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && dis_edge && !wr_en) |=> (state == ST_IDLE && !rep));

    // R10: clear state lasts one cycle and leaves defaults
    a_r10_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR) |=> (state == ST_IDLE && count == '0 && !expired && !rep));
endmodule

bind pmt_core pmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .wr_en    (wr_en),
    .tick     (tick),
    .dis_edge (dis_edge),
    .rep      (rep_q),
    .count    (cnt_q),
    .reload   (reload_q),
    .expired  (exp_q)
);

// File: tb/tb_pm_interval_timer.sv
`timescale 1ns/1ps
module tb_pm_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        local_stat = 1'b0;
    logic [1:0]  gev = '0;
    logic [3:0]  ev_n = 4'hF;
    logic        evt_o, expired_o;
    logic [15:0] count_o;

    int    vecs = 0;
    int    fails = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    pm_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .local_stat(local_stat), .gev(gev), .ev_n(ev_n),
        .evt_o(evt_o), .expired_o(expired_o), .count_o(count_o)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_en, m_ps, m_md, m_rep, m_sel, m_oe, m_reload, m_cnt, m_exp;
    int m_pulse, m_tog, m_run, m_sr, m_pc;
    bit a1 [0:7];
    bit a2 [0:7];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ps = 0; m_md = 0; m_rep = 0; m_sel = 0; m_oe = 0;
            m_reload = 0; m_cnt = 0; m_exp = 0; m_pulse = 0; m_tog = 0;
            m_run = 0; m_sr = 0; m_pc = 0;
            for (int i = 0; i < 8; i++) begin a1[i] = 0; a2[i] = 0; end
        end else begin
            bit edge_now, tk, ctlw, rlw, ex, sr_now;
            edge_now = (m_sel != 0) && a1[m_sel] && !a2[m_sel];
            tk = (m_run != 0) && (m_pc >= (1 << m_ps) - 1);
            m_pc = (m_run == 0 || tk) ? 0 : m_pc + 1;
            ex = 0; sr_now = 0;
            ctlw = wr_en && !wr_addr && (m_sr == 0);
            rlw  = wr_en &&  wr_addr && (m_sr == 0);
            if (m_sr != 0) begin
                m_sr = 0;
            end else if (ctlw && wr_data[6]) begin
                m_en = 0; m_ps = 0; m_md = 0; m_rep = 0; m_sel = 0; m_oe = 0;
                m_reload = 0; m_cnt = 0; m_exp = 0; m_run = 0;
                m_pulse = 0; m_tog = 0; m_sr = 1; sr_now = 1;
            end else begin
                if (ctlw) begin
                    m_en = wr_data[0]; m_ps = wr_data[3:1]; m_md = wr_data[5:4];
                    m_rep = wr_data[7]; m_sel = wr_data[13:11]; m_oe = wr_data[15];
                end
                if (rlw) begin
                    m_reload = wr_data;
                    if (m_run == 0) m_cnt = wr_data;
                end
                if (m_run == 0) begin
                    if (m_en != 0) begin
                        if (edge_now) begin m_en = 0; m_rep = 0; end
                        else begin m_run = 1; m_cnt = m_reload; m_exp = 0; end
                    end
                end else begin
                    if (edge_now) begin
                        m_en = 0; m_rep = 0; m_run = 0;
                    end else if (m_en == 0) begin
                        m_run = 0;
                    end else if (tk) begin
                        if (m_cnt <= 1) begin
                            ex = 1;
                            if (m_rep != 0) m_cnt = m_reload;
                            else begin m_cnt = 0; m_en = 0; m_exp = 1; m_run = 0; end
                        end else begin
                            m_cnt = m_cnt - 1;
                        end
                    end
                end
            end
            if (!sr_now) begin
                m_pulse = ex;
                m_tog = m_tog ^ ex;
            end
            for (int i = 0; i < 8; i++) a2[i] = a1[i];
            a1[0] = 0; a1[1] = local_stat; a1[2] = gev[0]; a1[3] = gev[1];
            for (int i = 0; i < 4; i++) a1[4+i] = ~ev_n[i];
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            bit e_evt;
            case (m_md)
                0: e_evt = (m_oe != 0) && (m_run != 0);
                1: e_evt = (m_oe != 0) && (m_pulse != 0);
                2: e_evt = (m_oe != 0) && (m_tog != 0);
                default: e_evt = 0;
            endcase
            vecs++;
            if (evt_o !== e_evt || expired_o !== m_exp[0] || count_o !== 16'(m_cnt)) begin
                fails++;
                $display("FAIL %s t=%0t evt=%b/%b expired=%b/%b count=%0d/%0d (actual/expected)",
                         cur_req, $time, evt_o, e_evt, expired_o, m_exp[0], count_o, m_cnt);
            end
        end
    end

    function automatic logic [15:0] mk(int en, int ps, int md, int rep, int sel, int oe, int sr = 0);
        logic [15:0] v;
        v = '0;
        v[0] = en[0]; v[3:1] = ps[2:0]; v[5:4] = md[1:0]; v[6] = sr[0];
        v[7] = rep[0]; v[13:11] = sel[2:0]; v[15] = oe[0];
        return v;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(bit a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic src_set(int s, bit active);
        case (s)
            1: local_stat = active;
            2: gev[0] = active;
            3: gev[1] = active;
            default: ev_n[s-4] = ~active;
        endcase
    endtask

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s directed check actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        cyc(1);
        cur_req = "R1";
        chk("R1", evt_o, 0); chk("R1", expired_o, 0); chk("R1", count_o, 0);

        cur_req = "R2";
        wr(1, 16'd5);
        chk("R2", count_o, 5);
        wr(0, mk(1, 0, 0, 0, 0, 1));
        chk("R2", evt_o, 1);
        cyc(2);
        chk("R2", count_o, 3);

        cur_req = "R4";
        cyc(3);
        chk("R4", expired_o, 1); chk("R4", count_o, 0); chk("R4", evt_o, 0);
        cyc(4);
        chk("R4", expired_o, 1);
        wr(0, mk(1, 0, 0, 0, 0, 1));
        chk("R4", expired_o, 0);
        cyc(8);

        cur_req = "R3";
        wr(1, 16'd2);
        wr(0, mk(1, 2, 0, 0, 0, 1));
        cyc(3);
        chk("R3", count_o, 2);
        cyc(1);
        chk("R3", count_o, 1);
        cyc(6);
        wr(1, 16'd2);
        wr(0, mk(1, 7, 0, 0, 0, 1));
        cyc(300);
        chk("R3", expired_o, 1);

        cur_req = "R5";
        wr(1, 16'd3);
        wr(0, mk(1, 0, 0, 1, 0, 1));
        cyc(3);
        chk("R5", count_o, 3); chk("R5", evt_o, 1);
        cyc(10);
        wr(1, 16'd1);
        cyc(8);
        wr(0, mk(0, 0, 0, 0, 0, 1));
        cyc(2);

        cur_req = "R9";
        wr(1, 16'd3);
        wr(0, mk(1, 0, 1, 1, 0, 1));
        cyc(20);
        wr(0, mk(1, 1, 2, 1, 0, 1));
        cyc(30);
        wr(0, mk(1, 0, 3, 1, 0, 1));
        cyc(10);
        chk("R9", evt_o, 0);
        wr(0, mk(0, 0, 0, 0, 0, 0));
        cyc(2);

        cur_req = "R8";
        wr(0, mk(1, 0, 0, 1, 0, 0));
        cyc(10);
        chk("R8", evt_o, 0);
        wr(0, mk(1, 0, 1, 1, 0, 0));
        cyc(10);
        wr(0, mk(0, 0, 0, 0, 0, 0));
        cyc(2);

        cur_req = "R6";
        for (int s = 1; s < 8; s++) begin
            wr(1, 16'd10);
            wr(0, mk(1, 0, 0, 1, s, 1));
            cyc(3);
            src_set(s, 1'b1);
            cyc(3);
            chk("R6", evt_o, 0);
            src_set(s, 1'b0);
            cyc(2);
        end
        wr(1, 16'd10);
        wr(0, mk(1, 0, 0, 1, 4, 1));
        cyc(2);
        src_set(5, 1'b1);
        src_set(2, 1'b1);
        cyc(4);
        chk("R6", evt_o, 1);
        src_set(5, 1'b0);
        src_set(2, 1'b0);
        wr(0, mk(1, 0, 0, 1, 0, 1));
        for (int s = 1; s < 8; s++) src_set(s, 1'b1);
        cyc(4);
        chk("R6", evt_o, 1);
        for (int s = 1; s < 8; s++) src_set(s, 1'b0);
        wr(0, mk(0, 0, 0, 0, 0, 1));
        cyc(2);

        cur_req = "R7";
        src_set(2, 1'b1);
        cyc(3);
        wr(1, 16'd6);
        wr(0, mk(1, 0, 0, 1, 2, 1));
        cyc(5);
        chk("R7", evt_o, 1);
        src_set(2, 1'b0);
        cyc(4);
        chk("R7", evt_o, 1);
        wr(0, mk(0, 0, 0, 0, 2, 1));
        wr(1, 16'd9);
        src_set(2, 1'b1);
        cyc(3);
        chk("R7", count_o, 9); chk("R7", evt_o, 0);
        src_set(2, 1'b0);
        wr(0, mk(0, 0, 0, 1, 3, 1));
        cyc(2);
        src_set(3, 1'b1);
        cyc(1);
        wr(0, mk(1, 0, 0, 1, 3, 1));
        cyc(2);
        chk("R7", evt_o, 0); chk("R7", count_o, 9);
        src_set(3, 1'b0);
        cyc(2);

        cur_req = "R10";
        wr(1, 16'd7);
        wr(0, mk(1, 0, 2, 1, 0, 1));
        cyc(9);
        wr(0, mk(0, 0, 0, 0, 0, 0, 1));
        wr(0, mk(1, 0, 0, 1, 0, 1));
        cyc(2);
        chk("R10", count_o, 0); chk("R10", evt_o, 0); chk("R10", expired_o, 0);
        wr(1, 16'd4);
        wr(0, mk(1, 0, 0, 0, 0, 1));
        cyc(2);
        chk("R10", count_o, 2);
        cyc(6);

        done = 1'b1;
        chk_on = 1'b0;
        summary();
        $finish;
    end
endmodule